// File: doc/BRIEF.md
# Per-Context Useful Runahead Distance Tracker

This block follows each hardware thread context through its runahead episodes. For each context it counts the instructions that pseudo-retire while the episode runs. Each time a long-latency load turns up, it takes a snapshot of that count. The snapshot taken at the last such load is the episode's useful distance: the point beyond which further speculative execution produced no more useful prefetches. The prediction table later uses this value.

An episode opens in one of two modes. In full mode it runs until the outside logic reports that the triggering miss has been serviced. In limited mode it also carries a predicted instruction limit. The block raises a termination request in the retirement cycle that brings the count up to that limit, and it closes the episode on its own. Whichever way an episode closes, the block presents one update record a cycle later. The record holds the useful distance, the identity of the load that opened the episode, and the cause of the close. The cause tells the table which of its distance fields to refresh.

All contexts are independent copies. Their strobes may arrive in any combination in the same cycle.

Top module: `runahead_distance_tracker`

## Requirements
- R1: After synchronous reset every context is idle, with `term_req`, `upd_valid`, `upd_dist`, `upd_load_id` and `upd_cause` all zero.
- R2: `ra_begin` opens a new episode. It clears the running count and the useful distance, and it captures `ra_limited`, `ra_limit` and `ra_load_id`. Retire, long-load and finish strobes in that same cycle are ignored. A begin during an open episode abandons the old one and produces no update for it.
- R3: While an episode is open, each cycle with `ra_retire` high adds one to the running count. The count saturates at 2^CNT_W-1 and does not wrap.
- R4: `ra_long_load` during an open episode copies the running count into the useful distance. If the same cycle also retires, the copied value includes that retirement. The last capture of the episode wins, and an episode with no capture reports a distance of 0.
- R5: `ra_finish` during an open episode closes it. In the next cycle `upd_valid` is high for exactly one cycle, with the useful distance on `upd_dist`, the captured load identity on `upd_load_id`, and `upd_cause` = 0 (miss serviced). Retire and long-load strobes in the finishing cycle still count.
- R6: In limited mode, `term_req` is high in the same cycle as the retirement that makes the incremented count equal the limit. That retirement closes the episode, and the next cycle shows the update with `upd_cause` = 1 (limit reached). Full mode never raises `term_req`.
- R7: A limited episode with a limit of 0 never raises `term_req`. It closes only on `ra_finish`.
- R8: On an idle context, the retire, long-load and finish strobes produce no termination request and no update.
- R9: Each context keeps its own state. Strobes for several contexts in the same cycle give the same results as if each context were driven alone.
- R10: If `ra_finish` and a limit-reaching retirement land in the same cycle, `term_req` still pulses and the single update reports `upd_cause` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra_begin | input | NUM_CTX | Per-context episode start strobe |
| ra_finish | input | NUM_CTX | Per-context strobe: triggering miss serviced |
| ra_retire | input | NUM_CTX | Per-context pseudo-retire strobe, one instruction |
| ra_long_load | input | NUM_CTX | Per-context long-latency load encountered |
| ra_limited | input | NUM_CTX | Mode at start: 1 limited, 0 full |
| ra_limit | input | NUM_CTX*CNT_W | Predicted instruction limit per context, captured at start |
| ra_load_id | input | NUM_CTX*ID_W | Identity of the episode-triggering load, captured at start |
| term_req | output | NUM_CTX | Early termination request, aligned with retirement |
| upd_valid | output | NUM_CTX | One-cycle table update strobe after an episode closes |
| upd_dist | output | NUM_CTX*CNT_W | Observed useful distance |
| upd_load_id | output | NUM_CTX*ID_W | Identity of the load that triggered the closed episode |
| upd_cause | output | NUM_CTX | 0: miss serviced (full), 1: limit reached |

## Verification
Two pairs of functions can fall into the same cycle. A long-load capture can share a cycle with the retirement that reaches the limit, in which case the reported distance must equal the limit. A serviced-miss finish can share a cycle with a limit-reaching retirement, in which case the request still pulses but the cause reads serviced. The bench provokes both by asserting the strobes together on one context, while other contexts run their own episodes at the same time. A behavioural reference model, compared on every clock, judges the termination request and every field of the update record.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    // Cause reported with a table update
    typedef enum logic {
        CAUSE_SERVICED = 1'b0,
        CAUSE_LIMIT    = 1'b1
    } end_cause_e;

    // Episode phase of one context
    typedef enum logic {
        CTX_IDLE      = 1'b0,
        CTX_RUNAHEAD  = 1'b1
    } ctx_phase_e;

    // Per-context strobe bundle
    typedef struct packed {
        logic begin_ep;
        logic finish_ep;
        logic retire;
        logic long_load;
        logic limited;
    } ctx_strobe_t;

    function automatic end_cause_e pick_cause(input logic serviced);
        return serviced ? CAUSE_SERVICED : CAUSE_LIMIT;
    endfunction

endpackage

// File: rtl/rdt_sat_counter.sv
module rdt_sat_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_next
);
    localparam logic [W-1:0] TOP = '1;

    always_comb begin
        if (clr)
            cnt_next = '0;
        else if (inc && (cnt != TOP))
            cnt_next = cnt + 1'b1;
        else
            cnt_next = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_next;
    end

    // R3: a saturated count stays saturated until cleared
    p_sat_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt == TOP && !clr) |=> (cnt == TOP));

    // R3: the count never moves by more than one step unless cleared
    p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt != TOP) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/rdt_limit_check.sv
module rdt_limit_check #(
    parameter int W = 12
) (
    input  logic         en,
    input  logic [W-1:0] reach,
    input  logic [W-1:0] limit,
    output logic         hit
);
    always_comb begin
        hit = en && (limit != '0) && (reach == limit);
    end
endmodule

// File: rtl/rdt_ctx_tracker.sv
module rdt_ctx_tracker
    import rdt_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int ID_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  ctx_strobe_t       stb,
    input  logic [CNT_W-1:0]  limit_in,
    input  logic [ID_W-1:0]   load_id_in,
    output logic              term_req,
    output logic              upd_valid,
    output logic [CNT_W-1:0]  upd_dist,
    output logic [ID_W-1:0]   upd_id,
    output end_cause_e        upd_cause
);
    ctx_phase_e        phase;
    logic              limited_q;
    logic [CNT_W-1:0]  limit_q;
    logic [CNT_W-1:0]  useful_q;
    logic [CNT_W-1:0]  useful_d;
    logic [ID_W-1:0]   id_q;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_next;
    logic              running;
    logic              step;
    logic              hit;
    logic              finish;

    assign running = (phase == CTX_RUNAHEAD) && !stb.begin_ep;
    assign step    = running && stb.retire;

    rdt_sat_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (stb.begin_ep),
        .inc      (step),
        .cnt      (cnt),
        .cnt_next (cnt_next)
    );

    rdt_limit_check #(.W(CNT_W)) u_lim (
        .en    (step && limited_q),
        .reach (cnt_next),
        .limit (limit_q),
        .hit   (hit)
    );

    // Snapshot of the running count at a long-latency load
    always_comb begin
        if (stb.begin_ep)
            useful_d = '0;
        else if (running && stb.long_load)
            useful_d = cnt_next;
        else
            useful_d = useful_q;
    end

    assign finish   = running && (stb.finish_ep || hit);
    assign term_req = hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= CTX_IDLE;
            limited_q <= 1'b0;
            limit_q   <= '0;
            id_q      <= '0;
            useful_q  <= '0;
            upd_valid <= 1'b0;
            upd_dist  <= '0;
            upd_id    <= '0;
            upd_cause <= CAUSE_SERVICED;
        end else begin
            useful_q  <= useful_d;
            upd_valid <= finish;
            if (stb.begin_ep) begin
                phase     <= CTX_RUNAHEAD;
                limited_q <= stb.limited;
                limit_q   <= limit_in;
                id_q      <= load_id_in;
            end else if (finish) begin
                phase     <= CTX_IDLE;
            end
            if (finish) begin
                upd_dist  <= useful_d;
                upd_id    <= id_q;
                upd_cause <= pick_cause(stb.finish_ep);
            end
        end
    end

    // R6: a termination request closes the episode
    p_term_closes_r6: assert property (@(posedge clk) disable iff (rst)
        term_req |=> (phase == CTX_IDLE));

    // R6: the termination request is a single-cycle pulse
    p_term_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        term_req |=> !term_req);

    // R6: a limit-caused update follows a termination request
    p_limit_cause_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_cause == CAUSE_LIMIT) |-> $past(term_req));

    // R5: the update strobe is a single-cycle pulse
    p_upd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> !upd_valid);

    // R4: the useful distance never exceeds the running count
    p_useful_le_cnt_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == CTX_RUNAHEAD) |-> (useful_q <= cnt));

    // R8: an idle context not being started produces no update
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == CTX_IDLE) |=> !upd_valid);

endmodule

// File: rtl/runahead_distance_tracker.sv
module runahead_distance_tracker
    import rdt_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int CNT_W   = 12,
    parameter int ID_W    = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CTX-1:0]       ra_begin,
    input  logic [NUM_CTX-1:0]       ra_finish,
    input  logic [NUM_CTX-1:0]       ra_retire,
    input  logic [NUM_CTX-1:0]       ra_long_load,
    input  logic [NUM_CTX-1:0]       ra_limited,
    input  logic [NUM_CTX*CNT_W-1:0] ra_limit,
    input  logic [NUM_CTX*ID_W-1:0]  ra_load_id,
    output logic [NUM_CTX-1:0]       term_req,
    output logic [NUM_CTX-1:0]       upd_valid,
    output logic [NUM_CTX*CNT_W-1:0] upd_dist,
    output logic [NUM_CTX*ID_W-1:0]  upd_load_id,
    output logic [NUM_CTX-1:0]       upd_cause
);
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        ctx_strobe_t stb;
        end_cause_e  cause_w;

        always_comb begin
            stb.begin_ep  = ra_begin[c];
            stb.finish_ep = ra_finish[c];
            stb.retire    = ra_retire[c];
            stb.long_load = ra_long_load[c];
            stb.limited   = ra_limited[c];
        end

        rdt_ctx_tracker #(.CNT_W(CNT_W), .ID_W(ID_W)) u_trk (
            .clk        (clk),
            .rst        (rst),
            .stb        (stb),
            .limit_in   (ra_limit[c*CNT_W +: CNT_W]),
            .load_id_in (ra_load_id[c*ID_W +: ID_W]),
            .term_req   (term_req[c]),
            .upd_valid  (upd_valid[c]),
            .upd_dist   (upd_dist[c*CNT_W +: CNT_W]),
            .upd_id     (upd_load_id[c*ID_W +: ID_W]),
            .upd_cause  (cause_w)
        );

        assign upd_cause[c] = cause_w;
    end

    // R1: no output activity during the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (upd_valid == '0));

endmodule

// File: tb/tb_runahead_distance_tracker.sv
module tb_runahead_distance_tracker;
    localparam int N    = 4;
    localparam int W    = 12;
    localparam int IW   = 10;
    localparam int MAXC = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [N-1:0]    ra_begin = '0, ra_finish = '0, ra_retire = '0, ra_long_load = '0, ra_limited = '0;
    logic [N*W-1:0]  ra_limit = '0;
    logic [N*IW-1:0] ra_load_id = '0;
    logic [N-1:0]    term_req, upd_valid, upd_cause;
    logic [N*W-1:0]  upd_dist;
    logic [N*IW-1:0] upd_load_id;

    runahead_distance_tracker #(.NUM_CTX(N), .CNT_W(W), .ID_W(IW)) dut (
        .clk(clk), .rst(rst),
        .ra_begin(ra_begin), .ra_finish(ra_finish), .ra_retire(ra_retire),
        .ra_long_load(ra_long_load), .ra_limited(ra_limited), .ra_limit(ra_limit),
        .ra_load_id(ra_load_id), .term_req(term_req), .upd_valid(upd_valid),
        .upd_dist(upd_dist), .upd_load_id(upd_load_id), .upd_cause(upd_cause)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // reference model state
    int m_act[N], m_cnt[N], m_use[N], m_lm[N], m_lim[N], m_id[N];
    int e_v[N], e_d[N], e_id[N], e_c[N];
    // observed updates
    int seen[N], last_d[N], last_id[N], last_c[N];

    task automatic chk(string req, int got, int exp, string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            for (int c = 0; c < N; c++) begin
                m_act[c] = 0; m_cnt[c] = 0; m_use[c] = 0; m_lm[c] = 0; m_lim[c] = 0; m_id[c] = 0;
                e_v[c] = 0; e_d[c] = 0; e_id[c] = 0; e_c[c] = 0;
            end
        end else if (!done) begin
            for (int c = 0; c < N; c++) begin
                int inc;
                int nu;
                bit hit;
                inc = (m_cnt[c] < MAXC) ? m_cnt[c] + 1 : MAXC;
                hit = m_act[c] != 0 && !ra_begin[c] && m_lm[c] != 0 && ra_retire[c] && inc == m_lim[c];
                chk(cur_req, int'(term_req[c]), int'(hit), $sformatf("ctx%0d term_req", c));
                chk(cur_req, int'(upd_valid[c]), e_v[c], $sformatf("ctx%0d upd_valid", c));
                if (e_v[c] != 0) begin
                    chk(cur_req, int'(upd_dist[c*W +: W]), e_d[c], $sformatf("ctx%0d upd_dist", c));
                    chk(cur_req, int'(upd_load_id[c*IW +: IW]), e_id[c], $sformatf("ctx%0d upd_load_id", c));
                    chk(cur_req, int'(upd_cause[c]), e_c[c], $sformatf("ctx%0d upd_cause", c));
                end
                if (upd_valid[c]) begin
                    seen[c]++;
                    last_d[c]  = int'(upd_dist[c*W +: W]);
                    last_id[c] = int'(upd_load_id[c*IW +: IW]);
                    last_c[c]  = int'(upd_cause[c]);
                end
                e_v[c] = 0;
                if (ra_begin[c]) begin
                    m_act[c] = 1; m_cnt[c] = 0; m_use[c] = 0;
                    m_lm[c] = int'(ra_limited[c]);
                    m_lim[c] = int'(ra_limit[c*W +: W]);
                    m_id[c] = int'(ra_load_id[c*IW +: IW]);
                end else if (m_act[c] != 0) begin
                    if (ra_retire[c]) m_cnt[c] = inc;
                    nu = ra_long_load[c] ? m_cnt[c] : m_use[c];
                    m_use[c] = nu;
                    if (ra_finish[c] || hit) begin
                        e_v[c] = 1; e_d[c] = nu; e_id[c] = m_id[c];
                        e_c[c] = ra_finish[c] ? 0 : 1;
                        m_act[c] = 0;
                    end
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        ra_begin = '0; ra_finish = '0; ra_retire = '0; ra_long_load = '0;
    endtask

    task automatic open_ep(int c, int id, bit lmode, int limit);
        ra_begin[c] = 1'b1;
        ra_limited[c] = lmode;
        ra_limit[c*W +: W] = W'(limit);
        ra_load_id[c*IW +: IW] = IW'(id);
    endtask

    task automatic clear_seen();
        for (int c = 0; c < N; c++) seen[c] = 0;
    endtask

    task automatic expect_last(int c, string req, int n, int d, int id, int cause);
        repeat (2) tick();
        chk(req, seen[c], n, $sformatf("ctx%0d update count", c));
        if (n > 0) begin
            chk(req, last_d[c], d, $sformatf("ctx%0d distance", c));
            chk(req, last_id[c], id, $sformatf("ctx%0d load id", c));
            chk(req, last_c[c], cause, $sformatf("ctx%0d cause", c));
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        clear_seen();
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk("R1", int'(upd_valid), 0, "upd_valid in reset");
        chk("R1", int'(term_req), 0, "term_req in reset");
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'(upd_dist), 0, "upd_dist after reset");
        chk("R1", int'(upd_load_id), 0, "upd_load_id after reset");
        chk("R1", int'(upd_cause), 0, "upd_cause after reset");
        @(posedge clk); #1;

        // full episode with captures, with and without retire
        cur_req = "R4"; clear_seen();
        open_ep(0, 5, 1'b0, 0); tick();
        for (int i = 1; i <= 10; i++) begin
            ra_retire[0] = 1'b1;
            if (i == 3 || i == 7) ra_long_load[0] = 1'b1;
            tick();
        end
        ra_long_load[0] = 1'b1; tick();
        ra_retire[0] = 1'b1; tick();
        ra_retire[0] = 1'b1; ra_finish[0] = 1'b1; tick();
        expect_last(0, "R5", 1, 10, 5, 0);

        // limited episode ends on the limit
        cur_req = "R6"; clear_seen();
        open_ep(1, 9, 1'b1, 6); tick();
        for (int i = 1; i <= 6; i++) begin
            ra_retire[1] = 1'b1;
            if (i == 4) ra_long_load[1] = 1'b1;
            if (i == 6) begin
                @(negedge clk);
                chk("R6", int'(term_req[1]), 1, "term_req on limit retire");
            end
            tick();
        end
        expect_last(1, "R6", 1, 4, 9, 1);

        // strobes after close are ignored
        cur_req = "R8"; clear_seen();
        for (int i = 0; i < 3; i++) begin
            ra_retire[1] = 1'b1; ra_long_load[1] = 1'b1; tick();
        end
        ra_finish[1] = 1'b1; ra_retire[3] = 1'b1; ra_long_load[3] = 1'b1; ra_finish[3] = 1'b1;
        tick();
        expect_last(1, "R8", 0, 0, 0, 0);
        expect_last(3, "R8", 0, 0, 0, 0);

        // limit of zero never terminates
        cur_req = "R7"; clear_seen();
        open_ep(2, 3, 1'b1, 0); tick();
        for (int i = 1; i <= 20; i++) begin
            ra_retire[2] = 1'b1;
            if (i == 15) ra_long_load[2] = 1'b1;
            tick();
        end
        ra_finish[2] = 1'b1; tick();
        expect_last(2, "R7", 1, 15, 3, 0);

        // all contexts at once
        cur_req = "R9"; clear_seen();
        open_ep(0, 1, 1'b0, 0); open_ep(1, 2, 1'b1, 5);
        open_ep(2, 3, 1'b0, 0); open_ep(3, 4, 1'b1, 8);
        tick();
        for (int i = 1; i <= 8; i++) begin
            ra_retire = '1;
            if (i == 2 || i == 6) ra_long_load[0] = 1'b1;
            if (i == 3) ra_long_load[1] = 1'b1;
            if (i == 8) begin ra_long_load[2] = 1'b1; ra_long_load[3] = 1'b1; ra_finish[0] = 1'b1; end
            tick();
        end
        ra_finish[2] = 1'b1; tick();
        expect_last(0, "R9", 1, 6, 1, 0);
        chk("R9", seen[1], 1, "ctx1 update count");
        chk("R9", last_d[1], 3, "ctx1 distance");
        chk("R9", last_c[1], 1, "ctx1 cause");
        chk("R9", last_d[2], 8, "ctx2 distance");
        chk("R9", last_c[2], 0, "ctx2 cause");
        chk("R9", last_d[3], 8, "ctx3 distance captured on limit cycle");
        chk("R9", last_id[3], 4, "ctx3 load id");
        chk("R9", last_c[3], 1, "ctx3 cause");

        // finish and limit reach in the same cycle
        cur_req = "R10"; clear_seen();
        open_ep(0, 7, 1'b1, 4); tick();
        for (int i = 1; i <= 4; i++) begin
            ra_retire[0] = 1'b1;
            if (i == 4) begin
                ra_finish[0] = 1'b1; ra_long_load[0] = 1'b1;
                @(negedge clk);
                chk("R10", int'(term_req[0]), 1, "term_req with finish");
            end
            tick();
        end
        expect_last(0, "R10", 1, 4, 7, 0);

        // restart abandons the open episode
        cur_req = "R2"; clear_seen();
        open_ep(2, 11, 1'b0, 0); tick();
        for (int i = 1; i <= 3; i++) begin
            ra_retire[2] = 1'b1; if (i == 2) ra_long_load[2] = 1'b1; tick();
        end
        open_ep(2, 12, 1'b0, 0); tick();
        ra_retire[2] = 1'b1; tick();
        ra_retire[2] = 1'b1; ra_long_load[2] = 1'b1; tick();
        ra_finish[2] = 1'b1; tick();
        expect_last(2, "R2", 1, 2, 12, 0);

        // strobes in the start cycle are ignored
        clear_seen();
        open_ep(3, 6, 1'b1, 1);
        ra_retire[3] = 1'b1; ra_long_load[3] = 1'b1; ra_finish[3] = 1'b1;
        tick();
        chk("R2", seen[3], 0, "ctx3 no update from start cycle");
        ra_finish[3] = 1'b1; tick();
        expect_last(3, "R2", 1, 0, 6, 0);

        // no long load gives zero distance
        cur_req = "R4"; clear_seen();
        open_ep(1, 13, 1'b0, 0); tick();
        for (int i = 0; i < 5; i++) begin ra_retire[1] = 1'b1; tick(); end
        ra_finish[1] = 1'b1; tick();
        expect_last(1, "R4", 1, 0, 13, 0);

        // full mode ignores the limit value
        cur_req = "R6"; clear_seen();
        open_ep(1, 14, 1'b0, 3); tick();
        for (int i = 0; i < 6; i++) begin ra_retire[1] = 1'b1; tick(); end
        expect_last(1, "R6", 0, 0, 0, 0);
        ra_finish[1] = 1'b1; tick();
        expect_last(1, "R6", 1, 0, 14, 0);

        // saturation of the running count
        cur_req = "R3"; clear_seen();
        open_ep(0, 15, 1'b0, 0); tick();
        for (int i = 0; i < MAXC + 5; i++) begin ra_retire[0] = 1'b1; tick(); end
        ra_long_load[0] = 1'b1; tick();
        ra_finish[0] = 1'b1; tick();
        expect_last(0, "R3", 1, MAXC, 15, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule